// File: doc/BRIEF.md
# UART Automatic Baud Rate Detector

This block times the bit period of an incoming asynchronous sync character, the byte 0x55, and leaves a 16-bit value that a baud rate generator can load as its divisor. Software arms the detector, the detector waits for a start bit, and it accumulates prescaler ticks from the first rising edge of RX after that start bit up to the fifth rising edge. The fifth rising edge falls on the stop bit. The alternating pattern of 0x55 makes this window exactly eight bit periods long, and it holds equal amounts of low and high time, so asymmetry in the line shows up only as a small averaged error.

The counter advances on a tick whose rate is one eighth of the generator clock picked by two select bits. The eight bit periods and the divide-by-eight cancel, so the total is the per-bit divisor. The counter always counts with its full width. A zero upper byte tells software that the result also fits an 8-bit divisor. A busy flag stays set during the measurement, and while it is set a hold output keeps the normal receiver idle. When the measurement ends, busy clears by itself and a receive-interrupt flag is raised. A data-read strobe clears that flag. If wake-up is enabled at arming time, the end of a break is passed over first.

Top module: `uab_autobaud`

## Requirements
- R1: An arm pulse is accepted only when `async_mode_i` is 1 and the block is idle. An arm pulse with `async_mode_i` at 0, or while busy, has no effect on `busy_o` or `count_o`.
- R2: An accepted arm sets `count_o` to 0, clears `ovf_o` and raises `busy_o` on the next clock edge. After reset all outputs are 0.
- R3: Once armed, the block waits for a falling edge of the two-flop-synchronized RX (start bit) and then for the next rising edge. From the cycle after that first rising edge up to and including the cycle of the fifth rising edge, every prescaler tick adds one to the count. For a 0x55 frame of B clocks per bit and a tick every cycle, the result is 8*B.
- R4: The tick period is 2^(PRE_SH + base) clocks. base is SLOW_SH for {sel_wide_i,sel_fast_i}=00, MID_SH for 01 and 10, and FAST_SH for 11. With the default parameters this gives 4096, 1024, 1024 and 256 system clocks, one eighth of divide-by-512, 128, 128 and 32.
- R5: The counter is always CNT_W (16) bits wide. A result below 256 leaves `count_o[15:8]` at zero, so 0x001C reads as low byte 0x1C and high byte 0x00.
- R6: On the fifth rising edge, `busy_o` falls and `irq_o` rises in the same cycle. After that, `count_o` holds until the next accepted arm.
- R7: A `data_rd_i` pulse clears `irq_o` on the next edge. If completion and a read fall in the same cycle, the flag is set.
- R8: `rx_hold_o` is high in exactly the cycles in which `busy_o` is high.
- R9: If `wake_en_i` is 1 at arming, the first rising edge of RX (the end of a break) is passed over before the start-bit search begins.
- R10: A tick with the count at 0xFFFF leaves the count at 0xFFFF and sets `ovf_o`. `ovf_o` stays set until the next accepted arm.
- R11: An `abort_i` pulse while busy returns the block to idle on the next edge. It leaves `count_o` unchanged and does not raise `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_i | input | 1 | Serial receive line, synchronized inside |
| async_mode_i | input | 1 | 1 when the serial port is in asynchronous mode |
| wake_en_i | input | 1 | Wake-up enable; skip a break before measuring |
| arm_i | input | 1 | One-cycle pulse that starts a measurement |
| abort_i | input | 1 | One-cycle pulse that cancels a measurement |
| sel_wide_i | input | 1 | Generator 16-bit mode select |
| sel_fast_i | input | 1 | Generator high-speed select |
| data_rd_i | input | 1 | Receive data read strobe, clears the interrupt |
| count_o | output | CNT_W | Measured divisor |
| busy_o | output | 1 | Measurement in progress (self-clearing enable) |
| irq_o | output | 1 | Receive-interrupt flag |
| rx_hold_o | output | 1 | Holds the normal receiver idle |
| ovf_o | output | 1 | Sticky counter saturation flag |

## Verification
The bench goes after the window boundaries. A design that also counted on the cycle of the first rising edge, or dropped the tick on the fifth, would be off by one from 8*B. A design that ended on the fourth edge would report three quarters of the value. The bench runs all four select combinations. A wrong tick rate for one of them would scale only that result, and a prescaler that restarts on arming would break the cycle-by-cycle agreement with the free-running model. It also covers a break ahead of the sync byte with wake-up set, a second arm in the middle of a measurement, an abort, and a run long enough to saturate. Each of these would show as a cleared count, a measurement that starts on the break's rising edge, a raised interrupt after abort, or a count that wraps to zero.

// File: rtl/uab_pkg.sv
package uab_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_BREAK = 3'd1,
    ST_START = 3'd2,
    ST_FIRST = 3'd3,
    ST_COUNT = 3'd4
  } uab_state_e;

  // Tick period exponent for a select pair: base shift plus the fixed
  // divide-by-eight style prescale.
  function automatic int unsigned tick_shift(input logic wide, input logic fast,
                                             input int unsigned slow_s,
                                             input int unsigned mid_s,
                                             input int unsigned fast_s,
                                             input int unsigned pre_s);
    int unsigned base;
    case ({wide, fast})
      2'b00:   base = slow_s;
      2'b11:   base = fast_s;
      default: base = mid_s;
    endcase
    return base + pre_s;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/uab_rx_edge.sv
module uab_rx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  output logic rise_o,
  output logic fall_o
);
  logic s1, s2, s3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1;
      s2 <= 1'b1;
      s3 <= 1'b1;
    end else begin
      s1 <= rx_i;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise_o = s2 & ~s3;
  assign fall_o = ~s2 & s3;

endmodule

// File: rtl/uab_prescale.sv
module uab_prescale #(
  parameter int unsigned SLOW_SH = 9,
  parameter int unsigned MID_SH  = 7,
  parameter int unsigned FAST_SH = 5,
  parameter int unsigned PRE_SH  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_wide_i,
  input  logic sel_fast_i,
  output logic tick_o
);
  import uab_pkg::*;

  localparam int unsigned MAX_SH = max3(SLOW_SH, MID_SH, FAST_SH) + PRE_SH;
  localparam int unsigned PW     = MAX_SH + 1;

  logic [PW-1:0] pcnt;
  logic [PW-1:0] mask;
  int unsigned   sh;

  always_ff @(posedge clk) begin
    if (!rst_n) pcnt <= '0;
    else        pcnt <= pcnt + PW'(1);
  end

  always_comb begin
    sh     = tick_shift(sel_wide_i, sel_fast_i, SLOW_SH, MID_SH, FAST_SH, PRE_SH);
    mask   = (PW'(1) << sh) - PW'(1);
    tick_o = ((pcnt & mask) == mask);
  end

endmodule

// File: rtl/uab_meas.sv
module uab_meas #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned EDGES = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             tick_i,
  input  logic             async_mode_i,
  input  logic             wake_en_i,
  input  logic             arm_i,
  input  logic             abort_i,
  input  logic             data_rd_i,
  output logic [CNT_W-1:0] count_o,
  output logic             busy_o,
  output logic             irq_o,
  output logic             ovf_o
);
  import uab_pkg::*;

  localparam int unsigned EW = $clog2(EDGES + 1);

  uab_state_e  state;
  logic [EW-1:0] ecnt;
  logic        arm_ok;
  logic        last_edge;
  logic        done;
  logic        kill;
  logic        sat_hit;

  assign busy_o    = (state != ST_IDLE);
  assign arm_ok    = (state == ST_IDLE) && arm_i && async_mode_i;
  assign kill      = abort_i && busy_o;
  assign last_edge = (ecnt == EW'(EDGES - 1));
  assign done      = (state == ST_COUNT) && rise_i && last_edge && !kill;
  assign sat_hit   = &count_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      ecnt    <= '0;
      count_o <= '0;
      ovf_o   <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      if (done)           irq_o <= 1'b1;
      else if (data_rd_i) irq_o <= 1'b0;

      if (kill) begin
        state <= ST_IDLE;
      end else begin
        case (state)
          ST_IDLE: if (arm_ok) begin
            count_o <= '0;
            ovf_o   <= 1'b0;
            ecnt    <= '0;
            state   <= wake_en_i ? ST_BREAK : ST_START;
          end
          ST_BREAK: if (rise_i) state <= ST_START;
          ST_START: if (fall_i) state <= ST_FIRST;
          ST_FIRST: if (rise_i) begin
            state <= ST_COUNT;
            ecnt  <= EW'(1);
          end
          ST_COUNT: begin
            if (tick_i) begin
              if (sat_hit) ovf_o   <= 1'b1;
              else         count_o <= count_o + CNT_W'(1);
            end
            if (rise_i) begin
              if (last_edge) state <= ST_IDLE;
              else           ecnt  <= ecnt + EW'(1);
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R2: busy only ever rises after an arm request
  assert_busy_from_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(arm_i) && $past(async_mode_i));

  // R6: busy falling without an abort means the interrupt was raised
  assert_done_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_o) && !$past(abort_i)) |-> irq_o);

  // R10: overflow flag only alongside a saturated count
  assert_ovf_at_max_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> (&count_o));

  // R6: an idle block without an arm keeps its result
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !arm_i) |=> $stable(count_o));

  // R3: the count never goes down during a measurement
  assert_count_mono_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (count_o >= $past(count_o)));

  // R11: abort never produces an interrupt
  assert_abort_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && abort_i && !irq_o && !data_rd_i) |=> (!busy_o && !irq_o));

endmodule

// File: rtl/uab_autobaud.sv
module uab_autobaud #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned SLOW_SH = 9,
  parameter int unsigned MID_SH  = 7,
  parameter int unsigned FAST_SH = 5,
  parameter int unsigned PRE_SH  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic             async_mode_i,
  input  logic             wake_en_i,
  input  logic             arm_i,
  input  logic             abort_i,
  input  logic             sel_wide_i,
  input  logic             sel_fast_i,
  input  logic             data_rd_i,
  output logic [CNT_W-1:0] count_o,
  output logic             busy_o,
  output logic             irq_o,
  output logic             rx_hold_o,
  output logic             ovf_o
);
  localparam int unsigned SYNC_RISES = 5;

  logic rx_rise;
  logic rx_fall;
  logic tick;

  uab_rx_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .rx_i   (rx_i),
    .rise_o (rx_rise),
    .fall_o (rx_fall)
  );

  uab_prescale #(
    .SLOW_SH (SLOW_SH),
    .MID_SH  (MID_SH),
    .FAST_SH (FAST_SH),
    .PRE_SH  (PRE_SH)
  ) u_pre (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_wide_i (sel_wide_i),
    .sel_fast_i (sel_fast_i),
    .tick_o     (tick)
  );

  uab_meas #(
    .CNT_W (CNT_W),
    .EDGES (SYNC_RISES)
  ) u_meas (
    .clk          (clk),
    .rst_n        (rst_n),
    .rise_i       (rx_rise),
    .fall_i       (rx_fall),
    .tick_i       (tick),
    .async_mode_i (async_mode_i),
    .wake_en_i    (wake_en_i),
    .arm_i        (arm_i),
    .abort_i      (abort_i),
    .data_rd_i    (data_rd_i),
    .count_o      (count_o),
    .busy_o       (busy_o),
    .irq_o        (irq_o),
    .ovf_o        (ovf_o)
  );

  assign rx_hold_o = busy_o;

  // R8: receiver hold tracks the measurement exactly
  assert_hold_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_hold_o == busy_o));

endmodule

// File: tb/tb_uab_autobaud.sv
module tb_uab_autobaud;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx = 1'b1;
  logic        async_mode = 1'b0;
  logic        wake_en = 1'b0;
  logic        arm = 1'b0;
  logic        abort_p = 1'b0;
  logic        sel_wide = 1'b1;
  logic        sel_fast = 1'b1;
  logic        data_rd = 1'b0;
  logic [15:0] count;
  logic        busy, irq, hold, ovf;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  uab_autobaud #(
    .CNT_W(16), .SLOW_SH(4), .MID_SH(2), .FAST_SH(0), .PRE_SH(0)
  ) dut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .async_mode_i(async_mode),
    .wake_en_i(wake_en), .arm_i(arm), .abort_i(abort_p),
    .sel_wide_i(sel_wide), .sel_fast_i(sel_fast), .data_rd_i(data_rd),
    .count_o(count), .busy_o(busy), .irq_o(irq), .rx_hold_o(hold), .ovf_o(ovf)
  );

  // ---------------- behavioural reference model ----------------
  int  m_phase;   // 0 idle, 1 skip break, 2 want start, 3 want first rise, 4 counting
  int  m_rises;
  int  m_cnt;
  bit  m_irq, m_ovf;
  bit  d1, d2, d3;
  longint cyc;

  function automatic int period(input logic w, input logic f);
    if (w && f) return 1;
    if (!w && !f) return 16;
    return 4;
  endfunction

  always @(posedge clk) begin
    bit up, down, tk, fin;
    if (!rst_n) begin
      m_phase = 0; m_rises = 0; m_cnt = 0; m_irq = 0; m_ovf = 0;
      d1 = 1; d2 = 1; d3 = 1; cyc = 0;
    end else begin
      up   = d2 && !d3;
      down = !d2 && d3;
      tk   = ((cyc % period(sel_wide, sel_fast)) == period(sel_wide, sel_fast) - 1);
      fin  = (m_phase == 4) && up && (m_rises == 4) && !abort_p;
      if (fin) m_irq = 1;
      else if (data_rd) m_irq = 0;
      if (abort_p && m_phase != 0) m_phase = 0;
      else if (m_phase == 0) begin
        if (arm && async_mode) begin
          m_cnt = 0; m_ovf = 0; m_rises = 0;
          m_phase = wake_en ? 1 : 2;
        end
      end else if (m_phase == 1) begin
        if (up) m_phase = 2;
      end else if (m_phase == 2) begin
        if (down) m_phase = 3;
      end else if (m_phase == 3) begin
        if (up) begin m_phase = 4; m_rises = 1; end
      end else begin
        if (tk) begin
          if (m_cnt == 65535) m_ovf = 1;
          else m_cnt = m_cnt + 1;
        end
        if (up) begin
          if (m_rises == 4) m_phase = 0;
          else m_rises = m_rises + 1;
        end
      end
      d3 = d2; d2 = d1; d1 = rx; cyc = cyc + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Lock-step comparison on every clock
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(count == 16'(m_cnt), "R3 lockstep count", count, m_cnt);
      check(busy == (m_phase != 0), "R2 lockstep busy", busy, m_phase != 0);
      check(irq == m_irq, "R7 lockstep irq", irq, m_irq);
      check(ovf == m_ovf, "R10 lockstep ovf", ovf, m_ovf);
      check(hold == busy, "R8 lockstep hold", hold, busy);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_arm();
    @(negedge clk); arm = 1; @(negedge clk); arm = 0;
  endtask

  task automatic pulse_abort();
    @(negedge clk); abort_p = 1; @(negedge clk); abort_p = 0;
  endtask

  task automatic pulse_rd();
    @(negedge clk); data_rd = 1; @(negedge clk); data_rd = 0;
  endtask

  task automatic send_sync(input int b);
    logic [7:0] ch;
    ch = 8'h55;
    rx = 0; idle(b);
    for (int i = 0; i < 8; i++) begin rx = ch[i]; idle(b); end
    rx = 1; idle(b);
  endtask

  task automatic measure(input bit w, input bit f, input int b, input int exp, input string tag);
    sel_wide = w; sel_fast = f;
    pulse_arm();
    send_sync(b);
    idle(4);
    check(count == 16'(exp), tag, count, exp);
    check(irq == 1 && busy == 0, "R6 done flags", {irq, busy}, 2'b10);
    pulse_rd();
  endtask

  // ---------------- main sequence ----------------
  initial begin
    idle(5);
    rst_n = 1;
    idle(2);
    check(count == 0 && busy == 0 && irq == 0 && hold == 0 && ovf == 0,
          "R2 reset state", {count, busy, irq, hold, ovf}, 0);

    // R1: arm ignored outside asynchronous mode
    async_mode = 0;
    pulse_arm(); idle(3);
    check(busy == 0, "R1 arm ignored when not async", busy, 0);

    // R2/R8: accepted arm
    async_mode = 1; sel_wide = 1; sel_fast = 1;
    pulse_arm();
    check(busy == 1 && hold == 1 && count == 0, "R2 R8 armed", {busy, hold, count}, 18'h30000);
    send_sync(4);
    idle(4);
    check(count == 16'd32, "R3 fast select count 8*B", count, 32);
    check(count[15:8] == 8'h00, "R5 upper byte zero", count[15:8], 0);
    check(irq == 1 && busy == 0 && hold == 0, "R6 R8 completion", {irq, busy, hold}, 3'b100);
    idle(5);
    check(count == 16'd32, "R6 count held after done", count, 32);
    pulse_rd();
    check(irq == 0, "R7 read clears irq", irq, 0);

    // R4: other select pairs
    measure(0, 1, 20, 40, "R4 select 01 count");
    measure(1, 0, 20, 40, "R4 select 10 count");
    measure(0, 0, 64, 32, "R4 select 00 count");

    // R9: break skipped with wake-up enabled
    sel_wide = 1; sel_fast = 1; wake_en = 1;
    pulse_arm();
    wake_en = 0;
    rx = 0; idle(30); rx = 1; idle(10);
    check(busy == 1 && count == 0, "R9 break end not counted", {busy, count}, 17'h10000);
    send_sync(5);
    idle(4);
    check(count == 16'd40 && irq == 1, "R9 measurement after break", count, 40);
    pulse_rd();

    // R1: second arm mid-measurement ignored
    pulse_arm();
    fork
      send_sync(6);
      begin idle(30); @(negedge clk); arm = 1; @(negedge clk); arm = 0; end
    join
    idle(4);
    check(count == 16'd48, "R1 re-arm while busy ignored", count, 48);
    pulse_rd();

    // R11: abort mid-measurement
    pulse_arm();
    rx = 0; idle(6); rx = 1; idle(20);
    pulse_abort();
    idle(1);
    check(busy == 0 && hold == 0 && irq == 0, "R11 abort to idle", {busy, hold, irq}, 0);
    rx = 0; idle(6); rx = 1; idle(10);
    check(busy == 0 && irq == 0, "R11 no irq after abort", {busy, irq}, 0);

    // R10: saturation and sticky overflow
    pulse_arm();
    rx = 0; idle(5); rx = 1; idle(65600);
    check(count == 16'hFFFF && ovf == 1 && busy == 1, "R10 saturate", {count, ovf, busy}, 18'h3FFFF);
    pulse_abort();
    idle(3);
    check(ovf == 1 && count == 16'hFFFF, "R10 overflow sticky", {ovf, count}, 17'h1FFFF);
    pulse_arm();
    check(ovf == 0 && count == 0, "R10 arm clears overflow", {ovf, count}, 0);
    pulse_abort();
    idle(3);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule